// File: doc/BRIEF.md
# Gearbox transmit sequencer

This block sits in front of a transmit gearbox that expects its sequence numbering from outside. Each user-clock cycle it presents a 7-bit sequence value, a 3-bit sync header and a data word to the gearbox. The framing (66-bit or 67-bit blocks) and the fabric word width (2 or 4 bytes) are fixed by parameters. The sequence counter runs freely from reset, and its wrap point and rate follow from those two choices.

The gearbox can ask for a pause. While pause is high, the block stops taking words from the upstream source: it drops its ready output in the same cycle and keeps its registered data and header unchanged. The sequence counter does not stop during a pause. The header is taken from upstream only on the first word of each block. With a 4-byte interface every word is a first word. With a 2-byte interface only the word taken while the internal phase bit is 0 is a first word.

Top module: `gbx_tx_seq`

## Requirements
- R1: With 66-bit framing, tx_seq counts 0, 1, …, 32 and then returns to 0.
- R2: With 67-bit framing, tx_seq counts 0, 1, …, 66 and then returns to 0.
- R3: With 66-bit framing, tx_seq bit 6 and tx_hdr bit 2 are always 0, even when up_hdr bit 2 is 1.
- R4: With a 4-byte interface (32-bit data), tx_seq advances on every rising clock edge.
- R5: With a 2-byte interface (16-bit data), a phase bit alternates 0, 1 starting from 0 after reset. tx_seq advances only on an edge where the phase is 1, so each value lasts exactly two cycles. The wrap points are the same as for the 4-byte interface.
- R6: A synchronous active-high rst clears tx_seq, tx_hdr, tx_data and the phase bit on the next rising edge.
- R7: In a cycle where gb_pause is 1, up_ready is 0 in that same cycle, tx_data and tx_hdr keep their values across the next edge, and tx_seq still counts. With gb_pause 0, up_ready is 1.
- R8: On an edge with gb_pause 0, up_data is registered and appears on tx_data after that edge.
- R9: tx_hdr loads up_hdr only on an edge with gb_pause 0 that carries a first word. That is every edge with a 4-byte interface and a phase-0 edge with a 2-byte interface. Otherwise tx_hdr holds its value.
- R10: With 67-bit framing, all three header bits pass through, and tx_seq reaches 66 with bit 6 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | User clock |
| rst | input | 1 | Synchronous reset, active high |
| up_data | input | BYTES*8 | Data word from the upstream source |
| up_hdr | input | 3 | Sync header from the upstream source |
| up_ready | output | 1 | Upstream may advance (low while paused) |
| gb_pause | input | 1 | Pause request from the gearbox |
| tx_seq | output | 7 | Sequence value to the gearbox |
| tx_hdr | output | 3 | Registered sync header to the gearbox |
| tx_data | output | BYTES*8 | Registered data word to the gearbox |

## Verification
up_ready is combinational, so its value is due in the same cycle as the pause input. It is checked 1 ns after the inputs are driven on the falling edge. tx_seq, tx_hdr and tx_data each pass through one register and are due after the first rising edge that follows the stimulus. For each driven cycle the bench pushes one expected item into a queue, and a monitor pops it 2 ns after the next rising edge. In this way every comparison lands on the exact edge that carries the result. Four instances cover every pairing of framing and width under the same stimulus. For the 2-byte instances this exposes both the two-cycle hold and the wrap.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

    typedef enum logic {
        FRM_66B = 1'b0,
        FRM_67B = 1'b1
    } framing_e;

    localparam int unsigned SEQ_W = 7;
    localparam int unsigned HDR_W = 3;

    typedef logic [SEQ_W-1:0] seq_t;
    typedef logic [HDR_W-1:0] hdr_t;

    // per-cycle control from the phase generator
    typedef struct packed {
        logic first;   // this word opens a block: header may load
        logic step;    // sequence counter advances on this edge
    } beat_t;

    function automatic seq_t last_count(input framing_e f);
        return (f == FRM_67B) ? seq_t'(66) : seq_t'(32);
    endfunction

    function automatic hdr_t mask_hdr(input framing_e f, input hdr_t h);
        return (f == FRM_67B) ? h : {1'b0, h[HDR_W-2:0]};
    endfunction

endpackage

// File: rtl/gbx_beat.sv
module gbx_beat
    import gbx_pkg::*;
#(
    parameter int unsigned BYTES = 2
) (
    input  logic  clk,
    input  logic  rst,
    output beat_t beat
);

    generate
        if (BYTES == 2) begin : g_half
            logic phase_q;

            always_ff @(posedge clk) begin
                if (rst) phase_q <= 1'b0;
                else     phase_q <= ~phase_q;
            end

            always_comb begin
                beat.first = ~phase_q;
                beat.step  = phase_q;
            end

            // R5
            phase_rise_chk: assert property (@(posedge clk) disable iff (rst)
                !phase_q |=> phase_q);
            // R5
            phase_fall_chk: assert property (@(posedge clk) disable iff (rst)
                phase_q |=> !phase_q);
        end else begin : g_full
            always_comb begin
                beat.first = 1'b1;
                beat.step  = 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/gbx_seq_ctr.sv
module gbx_seq_ctr
    import gbx_pkg::*;
#(
    parameter framing_e FRAMING = FRM_66B
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output seq_t seq
);

    localparam seq_t LAST = last_count(FRAMING);

    seq_t cnt_q;
    seq_t cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (step) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + seq_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign seq = cnt_q;

    // R1 R2
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && cnt_q == LAST) |=> cnt_q == '0);
    // R4
    incr_chk: assert property (@(posedge clk) disable iff (rst)
        (step && cnt_q != LAST) |=> cnt_q == $past(cnt_q) + seq_t'(1));
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cnt_q));
    // R1 R2
    range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/gbx_hold_reg.sv
module gbx_hold_reg
    import gbx_pkg::*;
#(
    parameter framing_e    FRAMING = FRM_66B,
    parameter int unsigned DW      = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pause,
    input  logic          first,
    input  logic [DW-1:0] in_data,
    input  hdr_t          in_hdr,
    output logic [DW-1:0] q_data,
    output hdr_t          q_hdr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_data <= '0;
            q_hdr  <= '0;
        end else if (!pause) begin
            q_data <= in_data;
            if (first) q_hdr <= mask_hdr(FRAMING, in_hdr);
        end
    end

    // R7
    pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pause |=> ($stable(q_data) && $stable(q_hdr)));
    // R8
    load_chk: assert property (@(posedge clk) disable iff (rst)
        !pause |=> q_data == $past(in_data));
    // R9
    hdr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !first |=> $stable(q_hdr));

endmodule

// File: rtl/gbx_tx_seq.sv
module gbx_tx_seq
    import gbx_pkg::*;
#(
    parameter framing_e    FRAMING = FRM_66B,
    parameter int unsigned BYTES   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BYTES*8-1:0]   up_data,
    input  logic [2:0]           up_hdr,
    output logic                 up_ready,
    input  logic                 gb_pause,
    output logic [6:0]           tx_seq,
    output logic [2:0]           tx_hdr,
    output logic [BYTES*8-1:0]   tx_data
);

    localparam int unsigned DW = BYTES * 8;

    beat_t beat;
    seq_t  seq;
    hdr_t  hdr;

    gbx_beat #(.BYTES(BYTES)) u_beat (
        .clk  (clk),
        .rst  (rst),
        .beat (beat)
    );

    gbx_seq_ctr #(.FRAMING(FRAMING)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .step (beat.step),
        .seq  (seq)
    );

    gbx_hold_reg #(.FRAMING(FRAMING), .DW(DW)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .pause   (gb_pause),
        .first   (beat.first),
        .in_data (up_data),
        .in_hdr  (up_hdr),
        .q_data  (tx_data),
        .q_hdr   (hdr)
    );

    assign up_ready = ~gb_pause;
    assign tx_seq   = seq;
    assign tx_hdr   = hdr;

    generate
        if (FRAMING == FRM_66B) begin : g_tie
            // R3
            tieoff_chk: assert property (@(posedge clk) disable iff (rst)
                (tx_seq[6] == 1'b0) && (tx_hdr[2] == 1'b0));
        end
    endgenerate

endmodule

// File: tb/tb_gbx_tx_seq.sv
module tb_gbx_tx_seq;
    import gbx_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic        rst;
    logic [31:0] up_data;
    logic [2:0]  up_hdr;
    logic        gb_pause;

    logic [3:0]  rdy;
    logic [6:0]  o_seq [4];
    logic [2:0]  o_hdr [4];
    logic [31:0] o_dat [4];
    logic [15:0] d16_1, d16_3;
    logic [31:0] d32_0, d32_2;

    // config c: 0 = 66/4B, 1 = 66/2B, 2 = 67/4B, 3 = 67/2B
    gbx_tx_seq #(.FRAMING(FRM_66B), .BYTES(4)) dut (
        .clk(clk), .rst(rst), .up_data(up_data), .up_hdr(up_hdr), .up_ready(rdy[0]),
        .gb_pause(gb_pause), .tx_seq(o_seq[0]), .tx_hdr(o_hdr[0]), .tx_data(d32_0));
    gbx_tx_seq #(.FRAMING(FRM_66B), .BYTES(2)) dut_66w2 (
        .clk(clk), .rst(rst), .up_data(up_data[15:0]), .up_hdr(up_hdr), .up_ready(rdy[1]),
        .gb_pause(gb_pause), .tx_seq(o_seq[1]), .tx_hdr(o_hdr[1]), .tx_data(d16_1));
    gbx_tx_seq #(.FRAMING(FRM_67B), .BYTES(4)) dut_67w4 (
        .clk(clk), .rst(rst), .up_data(up_data), .up_hdr(up_hdr), .up_ready(rdy[2]),
        .gb_pause(gb_pause), .tx_seq(o_seq[2]), .tx_hdr(o_hdr[2]), .tx_data(d32_2));
    gbx_tx_seq #(.FRAMING(FRM_67B), .BYTES(2)) dut_67w2 (
        .clk(clk), .rst(rst), .up_data(up_data[15:0]), .up_hdr(up_hdr), .up_ready(rdy[3]),
        .gb_pause(gb_pause), .tx_seq(o_seq[3]), .tx_hdr(o_hdr[3]), .tx_data(d16_3));

    assign o_dat[0] = d32_0;
    assign o_dat[1] = {16'h0, d16_1};
    assign o_dat[2] = d32_2;
    assign o_dat[3] = {16'h0, d16_3};

    typedef struct packed {
        logic [3:0][6:0]  seq;
        logic [3:0][2:0]  hdr;
        logic [3:0][31:0] dat;
        logic             paused;
        logic             in_rst;
    } exp_t;

    exp_t sb [$];

    int          checks = 0;
    int          errors = 0;
    int          m_cnt [4];
    bit          m_ph  [4];
    logic [31:0] m_dat [4];
    logic [2:0]  m_hdr [4];
    int          max_seen [4];
    bit          bit6_seen [4];

    task automatic chk(input bit ok, input string tag, input int c,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cfg=%0d actual=%0h expected=%0h at %0t", tag, c, act, exp, $time);
        end
    endtask

    // driver: applies one cycle of stimulus and pushes what the next edge must show
    task automatic step_cycle(input logic r, input logic [31:0] d, input logic [2:0] h, input logic p);
        exp_t e;
        @(negedge clk);
        rst = r; up_data = d; up_hdr = h; gb_pause = p;
        #1;
        for (int c = 0; c < 4; c++) chk(rdy[c] == ~p, "R7 ready", c, 32'(rdy[c]), 32'(~p));
        for (int c = 0; c < 4; c++) begin
            bit b4    = (c % 2 == 0);
            bit f67   = (c >= 2);
            int lim   = f67 ? 66 : 32;
            bit first = b4 || !m_ph[c];
            bit stp   = b4 || m_ph[c];
            if (r) begin
                m_cnt[c] = 0; m_ph[c] = 1'b0; m_dat[c] = '0; m_hdr[c] = '0;
            end else begin
                if (!p) begin
                    m_dat[c] = b4 ? d : {16'h0, d[15:0]};
                    if (first) m_hdr[c] = f67 ? h : {1'b0, h[1:0]};
                end
                if (stp) m_cnt[c] = (m_cnt[c] == lim) ? 0 : m_cnt[c] + 1;
                if (!b4) m_ph[c] = ~m_ph[c];
            end
            e.seq[c] = 7'(m_cnt[c]);
            e.hdr[c] = m_hdr[c];
            e.dat[c] = m_dat[c];
        end
        e.paused = p;
        e.in_rst = r;
        sb.push_back(e);
    endtask

    // monitor: compares each expected item 2 ns after the edge that produces it
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            for (int c = 0; c < 4; c++) begin
                string ts, td, th;
                if (e.in_rst) begin
                    ts = "R6"; td = "R6"; th = "R6";
                end else begin
                    if (c >= 2) ts = (c % 2 == 0) ? "R2/R4" : "R2/R5";
                    else        ts = (c % 2 == 0) ? "R1/R4" : "R1/R5";
                    td = e.paused ? "R7 data" : "R8";
                    th = e.paused ? "R7 hdr" : "R9";
                end
                chk(o_seq[c] === e.seq[c], ts, c, 32'(o_seq[c]), 32'(e.seq[c]));
                chk(o_dat[c] === e.dat[c], td, c, o_dat[c], e.dat[c]);
                chk(o_hdr[c] === e.hdr[c], th, c, 32'(o_hdr[c]), 32'(e.hdr[c]));
                if (c < 2)
                    chk(o_seq[c][6] === 1'b0 && o_hdr[c][2] === 1'b0, "R3 tie-off", c,
                        {o_seq[c][6], o_hdr[c][2]}, 32'h0);
                if (int'(o_seq[c]) > max_seen[c]) max_seen[c] = int'(o_seq[c]);
                if (o_seq[c][6] === 1'b1) bit6_seen[c] = 1'b1;
            end
        end
    end

    bit finished = 1'b0;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(8 * 5000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            m_cnt[c] = 0; m_ph[c] = 1'b0; m_dat[c] = '0; m_hdr[c] = '0;
            max_seen[c] = 0; bit6_seen[c] = 1'b0;
        end
        rst = 1'b1; up_data = '0; up_hdr = '0; gb_pause = 1'b0;
        // R6: reset state
        repeat (3) step_cycle(1'b1, 32'h0, 3'h0, 1'b0);
        // R1 R2 R4 R5: free run long enough for every wrap
        for (int i = 0; i < 150; i++)
            step_cycle(1'b0, {i[15:0] ^ 16'h5a00, 16'h1000 + i[15:0]}, 3'(i), 1'b0);
        // R7: scattered and burst pauses; header bit 2 set often (R3)
        for (int i = 0; i < 60; i++)
            step_cycle(1'b0, 32'hA000_0000 + 32'(i * 7), 3'(7 - (i % 8)),
                       (i % 3 == 1) || (i >= 40 && i < 46));
        // R6: reset mid-run
        repeat (2) step_cycle(1'b1, 32'hDEAD_BEEF, 3'h7, 1'b0);
        for (int i = 0; i < 30; i++)
            step_cycle(1'b0, 32'h0F0F_0000 + 32'(i), 3'(i + 3), (i % 4 == 2));
        @(negedge clk);
        @(negedge clk);
        // R1 R10: observed range of the sequence
        chk(max_seen[0] == 32, "R1 max", 0, 32'(max_seen[0]), 32);
        chk(max_seen[1] == 32, "R1 max", 1, 32'(max_seen[1]), 32);
        chk(max_seen[2] == 66 && bit6_seen[2], "R10", 2, 32'(max_seen[2]), 66);
        chk(max_seen[3] == 66 && bit6_seen[3], "R10", 3, 32'(max_seen[3]), 66);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule